// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets software on a register bus run Clause 45 management transactions toward external PHY devices over a two-wire MDC/MDIO link. Software writes one 32-bit frame word that holds every field of the management frame. It then raises a launch bit in a control word. The block produces MDC from the system clock and sends a run of all-ones preamble. It then shifts the frame word onto MDIO, most significant bit first. On a read, the block stops driving MDIO for the turnaround and data bits. It samples the PHY's 16 data bits and writes them into the low half of the same frame word. Software polls a busy bit to learn when the frame has finished.

A register access to a PHY register always takes two frames: an address frame, then a write or read frame to the same port and device. The block treats each frame on its own. Software does the sequencing.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, the status busy bit, MDC and the MDIO output enable are 0, and the frame word reads 0.
- R2: A write to the control word (offset 0) whose bit 3 is 1 starts a frame only when the bit 3 stored before that write was 0. Writing bit 3 as 1 while it is already 1 starts nothing.
- R3: Status bit 0 (offset 2) reads 1 from the cycle after the launching write, for exactly 64 x CLK_DIV cycles. It then reads 0.
- R4: While busy, MDC has a period of CLK_DIV system clocks, low for the first half of each bit and high for the second. While idle, MDC is held low.
- R5: Each frame sends PRE_LEN ones, then the 32 bits of the frame word (offset 1) from bit 31 down to bit 0. MDIO changes only where MDC falls.
- R6: When frame bits 29:28 equal 11 (read), the output enable drops from the first turnaround bit (frame bit 17) to the end of the frame, and MDIO is 0 while it is not driven.
- R7: On a read, the 16 bits sampled at the MDC rising edges of the data bits replace frame bits 15:0, earliest bit as bit 15, when the frame ends. Bits 31:16 keep their value.
- R8: A rising edge of control bit 3 while busy is ignored, and the frame in progress keeps its length.
- R9: A write to the frame word while busy is ignored. The frame word read after the frame ends holds the launched value, or that value with read data merged in.
- R10: For opcodes 00 (address), 01 (write) and 10, MDIO is driven for the whole frame, including the turnaround bits taken from the frame word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 2 | Write offset: 0 control, 1 frame, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 2 | Read offset |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions assume that software changes the frame word only while the block is idle. They also assume that the frame register changes in the middle of a frame only through the blocked write path. Both the opcode-based release check and the stable-frame check depend on this. The bench writes registers only at falling clock edges, one write per cycle. It launches frames only through 0-1-0 sequences on control bit 3. It also aims mid-frame writes at both the control and frame words, to show that they are ignored. The bench models the PHY from its own frame timing, so mdio_i is valid at every sampling edge.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
   localparam int FRAME_W = 32;
   localparam int DATA_W  = 16;
   localparam int OP_HI   = 29;
   localparam int OP_LO   = 28;
   localparam int GO_BIT  = 3;

   typedef enum logic [1:0] {
      OP_ADDR  = 2'b00,
      OP_WRITE = 2'b01,
      OP_RSV   = 2'b10,
      OP_READ  = 2'b11
   } op_e;

   localparam logic [1:0] REG_CTRL  = 2'd0;
   localparam logic [1:0] REG_FRAME = 2'd1;
   localparam logic [1:0] REG_STAT  = 2'd2;
endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
   parameter int CLK_DIV = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int DIV_W = $clog2(CLK_DIV);

   if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 4");
   end

   logic [DIV_W-1:0] cnt;

   assign rise_tick = run && (cnt == DIV_W'(HALF - 1));
   assign fall_tick = run && (cnt == DIV_W'(CLK_DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= fall_tick ? '0 : cnt + 1'b1;
         if (rise_tick)      mdc <= 1'b1;
         else if (fall_tick) mdc <= 1'b0;
      end
   end
endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
   import mdio_c45_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [1:0]         bus_waddr,
   input  logic [FRAME_W-1:0] bus_wdata,
   input  logic [1:0]         bus_raddr,
   output logic [FRAME_W-1:0] bus_rdata,
   input  logic               busy,
   input  logic               cap_we,
   input  logic [DATA_W-1:0]  cap_data,
   output logic [FRAME_W-1:0] frame_q,
   output logic               start_pulse
);
   logic [FRAME_W-1:0] ctrl_q;
   logic               wr_ctrl, wr_frame;

   assign wr_ctrl     = bus_we && (bus_waddr == REG_CTRL);
   assign wr_frame    = bus_we && (bus_waddr == REG_FRAME);
   assign start_pulse = wr_ctrl && bus_wdata[GO_BIT] && !ctrl_q[GO_BIT] && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         frame_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata;
         if (cap_we)
            frame_q[DATA_W-1:0] <= cap_data;
         else if (wr_frame && !busy)
            frame_q <= bus_wdata;
      end
   end

   always_comb begin
      unique case (bus_raddr)
         REG_CTRL:  bus_rdata = ctrl_q;
         REG_FRAME: bus_rdata = frame_q;
         REG_STAT:  bus_rdata = {{(FRAME_W-1){1'b0}}, busy};
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_c45_shifter.sv
module mdio_c45_shifter
   import mdio_c45_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   input  logic               rise_tick,
   input  logic               fall_tick,
   input  logic               mdio_i,
   output logic               busy,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               cap_we,
   output logic [DATA_W-1:0]  cap_data
);
   localparam int TOTAL   = PRE_LEN + FRAME_W;
   localparam int BIT_W   = $clog2(TOTAL);
   localparam int TA_POS  = PRE_LEN + (FRAME_W - 18);
   localparam int DAT_POS = PRE_LEN + (FRAME_W - DATA_W);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end

   logic [BIT_W-1:0] bit_idx;
   logic [BIT_W-1:0] fld_idx;
   logic [4:0]       sel;
   logic             is_read, in_pre, released, cur_bit, last_bit;
   logic [DATA_W-1:0] cap_sr;

   assign is_read  = op_e'(frame[OP_HI:OP_LO]) == OP_READ;
   assign in_pre   = bit_idx < BIT_W'(PRE_LEN);
   assign fld_idx  = bit_idx - BIT_W'(PRE_LEN);
   assign sel      = 5'(FRAME_W - 1) - fld_idx[4:0];
   assign cur_bit  = in_pre ? 1'b1 : frame[sel];
   assign released = is_read && (bit_idx >= BIT_W'(TA_POS));
   assign last_bit = bit_idx == BIT_W'(TOTAL - 1);

   assign mdio_oe  = busy && !released;
   assign mdio_o   = mdio_oe && cur_bit;
   assign cap_we   = busy && fall_tick && last_bit && is_read;
   assign cap_data = cap_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bit_idx <= '0;
         cap_sr  <= '0;
      end else begin
         if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
         end else if (busy && fall_tick) begin
            if (last_bit) begin
               busy    <= 1'b0;
               bit_idx <= '0;
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end
         if (busy && rise_tick && is_read && bit_idx >= BIT_W'(DAT_POS))
            cap_sr <= {cap_sr[DATA_W-2:0], mdio_i};
      end
   end
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
   import mdio_c45_pkg::*;
#(
   parameter int CLK_DIV = 40,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_we,
   input  logic [1:0]  bus_waddr,
   input  logic [31:0] bus_wdata,
   input  logic [1:0]  bus_raddr,
   output logic [31:0] bus_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic               busy, start_pulse, rise_tick, fall_tick, cap_we;
   logic [DATA_W-1:0]  cap_data;
   logic [FRAME_W-1:0] frame_q;

   mdio_c45_regs u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
      .busy(busy), .cap_we(cap_we), .cap_data(cap_data),
      .frame_q(frame_q), .start_pulse(start_pulse)
   );

   mdio_c45_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
      .rise_tick(rise_tick), .fall_tick(fall_tick)
   );

   mdio_c45_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start_pulse), .frame(frame_q),
      .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
      .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .cap_we(cap_we), .cap_data(cap_data)
   );
endmodule

// File: rtl/mdio_c45_checker.sv
module mdio_c45_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        start_pulse,
   input logic [31:0] frame_q
);
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   a_r3_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_pulse));

   a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

   a_r6_release_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(mdio_oe)) |-> (frame_q[29:28] == 2'b11));

   a_r9_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(frame_q));
endmodule

bind mdio_c45_master mdio_c45_checker u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
   .mdio_oe(mdio_oe), .start_pulse(start_pulse), .frame_q(frame_q)
);

// File: tb/mdio_c45_master_bench.sv
module mdio_c45_master_bench;
   localparam int DIV   = 8;
   localparam int HALF  = DIV / 2;
   localparam int PRE   = 32;
   localparam int NBITS = PRE + 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_waddr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [1:0]  bus_raddr = 2'd2;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   mdio_c45_master #(.CLK_DIV(DIV), .PRE_LEN(PRE)) u_mdio_c45_master (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // behavioural reference model
   logic        m_busy;
   int          m_k;
   logic [31:0] m_frame, m_ctrl;
   logic [15:0] m_cap, phy_word;
   logic        m_read;
   int          m_bit, m_phase;

   assign m_read  = m_frame[29:28] == 2'b11;
   assign m_bit   = m_k / DIV;
   assign m_phase = m_k % DIV;
   assign mdio_i  = (m_busy && m_read && m_bit >= PRE + 16) ?
                    phy_word[15 - (m_bit - PRE - 16)] : 1'b1;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_busy <= 1'b0; m_k <= 0; m_frame <= '0; m_ctrl <= '0; m_cap <= '0;
      end else begin
         if (m_busy) begin
            if (m_phase == HALF - 1 && m_read && m_bit >= PRE + 16)
               m_cap <= {m_cap[14:0], mdio_i};
            if (m_k == NBITS * DIV - 1) begin
               m_busy <= 1'b0;
               if (m_read) m_frame[15:0] <= m_cap;
            end
            m_k <= m_k + 1;
         end
         if (bus_we && bus_waddr == 2'd0) begin
            m_ctrl <= bus_wdata;
            if (bus_wdata[3] && !m_ctrl[3] && !m_busy) begin
               m_busy <= 1'b1; m_k <= 0;
            end
         end
         if (bus_we && bus_waddr == 2'd1 && !m_busy) m_frame <= bus_wdata;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   logic e_mdc, e_oe, e_o, e_val;
   logic [31:0] e_rd;
   bit   oe_low_seen;
   always @(negedge clk) begin
      if (rst_n) begin
         e_val = (m_bit < PRE) ? 1'b1 : m_frame[31 - (m_bit - PRE)];
         e_mdc = m_busy && (m_phase >= HALF);
         e_oe  = m_busy && !(m_read && m_bit >= PRE + 14);
         e_o   = e_oe && e_val;
         case (bus_raddr)
            2'd0: e_rd = m_ctrl;
            2'd1: e_rd = m_frame;
            2'd2: e_rd = {31'd0, m_busy};
            default: e_rd = 32'd0;
         endcase
         check(mdc == e_mdc, "R4 mdc", {31'd0, mdc}, {31'd0, e_mdc});
         check(mdio_oe == e_oe, "R6/R10 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
         check(mdio_o == e_o, "R5 mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
         check(bus_rdata == e_rd, "R3/R7 rdata", bus_rdata, e_rd);
         if (m_busy && !mdio_oe) oe_low_seen = 1'b1;
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic wait_idle(input int t0, output int dur);
      bus_raddr = 2'd2;
      do @(negedge clk); while (bus_rdata[0]);
      dur = cyc - t0;
   endtask

   task automatic run_frame(input logic [31:0] f, input logic [15:0] phy,
                            output int dur);
      int t0;
      phy_word = phy;
      bus_write(2'd1, f);
      bus_write(2'd0, 32'd5);
      bus_write(2'd0, 32'd13);
      t0 = cyc;
      bus_write(2'd0, 32'd5);
      oe_low_seen = 1'b0;
      wait_idle(t0, dur);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int dur, t0;
      logic [31:0] f;
      phy_word = 16'h0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {30'd0, mdc, mdio_oe}, 32'd0);
      bus_raddr = 2'd2;  #1;
      check(bus_rdata == 32'd0, "R1 busy clear", bus_rdata, 32'd0);
      bus_raddr = 2'd1;  #1;
      check(bus_rdata == 32'd0, "R1 frame clear", bus_rdata, 32'd0);

      // address frame (opcode 00), R3 length, R10 driven throughout
      f = {2'b00, 2'b00, 5'h0A, 5'h05, 2'b10, 16'h1234};
      run_frame(f, 16'h0, dur);
      check(dur == NBITS * DIV, "R3 busy length", dur, NBITS * DIV);
      check(!oe_low_seen, "R10 address frame driven", {31'd0, oe_low_seen}, 32'd0);

      // write frame (opcode 01)
      f = {2'b00, 2'b01, 5'h1F, 5'h01, 2'b10, 16'hBEEF};
      run_frame(f, 16'h0, dur);
      check(!oe_low_seen, "R10 write frame driven", {31'd0, oe_low_seen}, 32'd0);

      // opcode 10 is driven too
      f = {2'b00, 2'b10, 5'h03, 5'h07, 2'b10, 16'h00F0};
      run_frame(f, 16'h0, dur);
      check(!oe_low_seen, "R10 opcode 10 driven", {31'd0, oe_low_seen}, 32'd0);

      // read frame (opcode 11), R6 release, R7 capture
      f = {2'b00, 2'b11, 5'h11, 5'h05, 2'b10, 16'h0000};
      run_frame(f, 16'hA5C3, dur);
      check(oe_low_seen, "R6 read releases mdio", {31'd0, oe_low_seen}, 32'd1);
      bus_raddr = 2'd1; #1;
      check(bus_rdata == {f[31:16], 16'hA5C3}, "R7 read data merged", bus_rdata,
            {f[31:16], 16'hA5C3});

      // second read with different data pattern
      f = {2'b00, 2'b11, 5'h02, 5'h1E, 2'b10, 16'hFFFF};
      run_frame(f, 16'h1E69, dur);
      bus_raddr = 2'd1; #1;
      check(bus_rdata == {f[31:16], 16'h1E69}, "R7 second read", bus_rdata,
            {f[31:16], 16'h1E69});

      // R8 restart while busy ignored, R9 frame write while busy ignored
      f = {2'b00, 2'b01, 5'h04, 5'h02, 2'b10, 16'h5A5A};
      phy_word = 16'h0;
      bus_write(2'd1, f);
      bus_write(2'd0, 32'd5);
      bus_write(2'd0, 32'd13);
      t0 = cyc;
      bus_write(2'd0, 32'd5);
      repeat (100) @(negedge clk);
      bus_write(2'd0, 32'd13);
      bus_write(2'd1, 32'hFFFF_FFFF);
      bus_write(2'd0, 32'd5);
      wait_idle(t0, dur);
      check(dur == NBITS * DIV, "R8 no restart while busy", dur, NBITS * DIV);
      bus_raddr = 2'd1; #1;
      check(bus_rdata == f, "R9 frame write ignored while busy", bus_rdata, f);

      // R2 bit 3 already high: no new frame
      bus_write(2'd0, 32'd13);
      bus_raddr = 2'd2; #1;
      check(bus_rdata[0] == 1'b1, "R2 start on rising bit 3", {31'd0, bus_rdata[0]}, 32'd1);
      t0 = cyc - 1;
      wait_idle(t0, dur);
      bus_write(2'd0, 32'd13);
      #1;
      check(bus_rdata[0] == 1'b0 && mdio_oe == 1'b0, "R2 no start without edge",
            {30'd0, bus_rdata[0], mdio_oe}, 32'd0);
      repeat (DIV * 2) @(negedge clk);
      check(mdc == 1'b0, "R4 mdc low when idle", {31'd0, mdc}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule